// File: doc/BRIEF.md
# Chainable Event Counter Pair

This block holds two event counters: an even counter (index 0) and an odd counter (index 1). Each counter has its own type register. The type register picks one line from a vector of single-cycle event inputs, and the counter advances by one on each cycle in which that line is high. The two counters share an enable mask, a global run bit and a two-bit sticky overflow status.

The odd counter can be given the chain code. In that case it stops following an input line and instead counts wraps of the even counter. The pair then behaves as one counter twice as wide. The type can be switched between a plain event and the chain code at any time, and the next wrap of the even counter is handled under the new setting. Software reaches every register through a single-cycle write port and a combinational read port.

Top module: `evt_pair_ctr`

## Requirements
- R1: When counter n is running, it advances by one on each cycle in which `evt_i[type_n]` is high. Type codes are 0x11 for cycles, 0x13 for memory access and 0x1E for chain. An even counter typed 0x1E never advances.
- R2: Writing address 1 sets the enable bits that are 1 in `wdata_i[1:0]`. Writing address 2 clears the enable bits that are 1 in `wdata_i[1:0]`. Bit n refers to counter n, and reads of either address return the enable mask.
- R3: No counter advances while bit 0 of the control register (address 0) is 0.
- R4: While the odd type is 0x1E and the even counter is not running, neither counter changes.
- R5: With both counters running and the odd type 0x1E, a wrap of the even counter from all ones to zero adds one to the odd counter and leaves overflow bit 0 clear.
- R6: A wrap of the even counter while the odd counter is disabled, or while the odd type is not 0x1E, sets overflow bit 0 and leaves the odd counter unchanged.
- R7: Writes to a type register or to the enable mask apply from the next cycle onward. No reset is needed when the odd type moves between a plain event and the chain code.
- R8: Reset clears both counters, the overflow status, the enable mask, the types and the control bit.
- R9: The overflow status (address 3) is write-one-to-clear. A flag raised in the same cycle as its clear stays set.
- R10: A wrap of the odd counter past all ones sets overflow bit 1.
- R11: A write to a counter register (address 4 for the even counter, 5 for the odd counter) loads the written value in that cycle. The write overrides any increment or carry into that counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address. 0 control, 1 enable set, 2 enable clear, 3 overflow, 4 even count, 5 odd count, 6 even type, 7 odd type |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for `addr_i`, combinational |
| evt_i | input | EVT_NUM | Single-cycle event lines, indexed by type code |

## Verification
The bench starts the even counter a few counts below its wrap point and targets the cases where the overflow decision can go wrong. Chaining can be switched on or off in the middle of a run, either by clearing the odd enable or by rewriting the odd type. A design that reads stale configuration would carry into the odd counter when it should flag an overflow, or flag one when it should carry. The bench also runs a chained counter with the even counter disabled: a design that leaks carries would advance the odd counter. Finally, it checks a full 64-bit wrap, which must raise only status bit 1, and the cycles where a clear collides with a new flag or a count write collides with an event. In those cycles a wrong priority would lose the flag or drop the written value.

// File: rtl/evt_pair_pkg.sv
package evt_pair_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [7:0] EVT_CYC   = 8'h11;
  localparam logic [7:0] EVT_MEM   = 8'h13;
  localparam logic [7:0] EVT_CHAIN = 8'h1E;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_EN_SET = 3'd1,
    A_EN_CLR = 3'd2,
    A_OVF    = 3'd3,
    A_CNT0   = 3'd4,
    A_CNT1   = 3'd5,
    A_TYPE0  = 3'd6,
    A_TYPE1  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/evt_pair_cfg.sv
module evt_pair_cfg
  import evt_pair_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TYPE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              glb_o,
  output logic [1:0]        en_o,
  output logic [1:0]        run_o,
  output logic [TYPE_W-1:0] type0_o,
  output logic [TYPE_W-1:0] type1_o
);
  logic              glb_q;
  logic [1:0]        en_q;
  logic [TYPE_W-1:0] t0_q, t1_q;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:TYPE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_q <= 1'b0;
      en_q  <= '0;
      t0_q  <= '0;
      t1_q  <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(addr_i))
        A_CTRL:   glb_q <= wdata_i[0];
        A_EN_SET: en_q  <= en_q | wdata_i[1:0];
        A_EN_CLR: en_q  <= en_q & ~wdata_i[1:0];
        A_TYPE0:  t0_q  <= wdata_i[TYPE_W-1:0];
        A_TYPE1:  t1_q  <= wdata_i[TYPE_W-1:0];
        default: ;
      endcase
    end
  end

  assign glb_o   = glb_q;
  assign en_o    = en_q;
  assign run_o   = en_q & {2{glb_q}};
  assign type0_o = t0_q;
  assign type1_o = t1_q;

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_EN_SET) |=> ((en_o & $past(wdata_i[1:0])) == $past(wdata_i[1:0]))); // R2
  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_EN_CLR) |=> ((en_o & $past(wdata_i[1:0])) == 2'b00)); // R2
endmodule

// File: rtl/evt_pair_cnt.sv
module evt_pair_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i & ~ld_i & (&cnt_q);

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ld_i) |=> $stable(cnt_o)); // R3
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_o == $past(ld_val_i))); // R11
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !ld_i) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R1
endmodule

// File: rtl/evt_pair_ovf.sv
module evt_pair_ovf (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] set_i,
  input  logic       clr_we_i,
  input  logic [1:0] clr_mask_i,
  output logic [1:0] ovf_o
);
  logic [1:0] ovf_q;
  logic [1:0] clr;

  assign clr = clr_we_i ? clr_mask_i : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else         ovf_q <= (ovf_q & ~clr) | set_i;
  end

  assign ovf_o = ovf_q;

  AST_OVF_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != 2'b00) |=> ((ovf_o & $past(set_i)) == $past(set_i))); // R9
  AST_OVF_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && set_i == 2'b00) |=> ((ovf_o & $past(clr_mask_i)) == 2'b00)); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o))); // R9
endmodule

// File: rtl/evt_pair_ctr.sv
module evt_pair_ctr
  import evt_pair_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned EVT_NUM = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]   rdata_o,
  input  logic [EVT_NUM-1:0] evt_i
);
  localparam int unsigned TYPE_W = $clog2(EVT_NUM);
  localparam logic [TYPE_W-1:0] CHAIN_T = TYPE_W'(EVT_CHAIN);

  logic              glb;
  logic [1:0]        en, run, ovf, ovf_set;
  logic [TYPE_W-1:0] type0, type1;
  logic              chain, inc0, inc1, wrap0, wrap1, ld0, ld1;
  logic [CNT_W-1:0]  cnt0, cnt1;

  evt_pair_cfg #(.DATA_W(CNT_W), .TYPE_W(TYPE_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .glb_o(glb), .en_o(en), .run_o(run),
    .type0_o(type0), .type1_o(type1)
  );

  assign chain = (type1 == CHAIN_T);
  assign ld0   = wr_en_i && (addr_i == A_CNT0);
  assign ld1   = wr_en_i && (addr_i == A_CNT1);
  // even counter never treats the chain code as a live event line
  assign inc0  = run[0] & (type0 != CHAIN_T) & evt_i[type0];
  assign inc1  = run[1] & (chain ? wrap0 : evt_i[type1]);

  evt_pair_cnt #(.CNT_W(CNT_W)) u_cnt0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld0), .ld_val_i(wdata_i),
    .inc_i(inc0), .cnt_o(cnt0), .wrap_o(wrap0)
  );

  evt_pair_cnt #(.CNT_W(CNT_W)) u_cnt1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld1), .ld_val_i(wdata_i),
    .inc_i(inc1), .cnt_o(cnt1), .wrap_o(wrap1)
  );

  assign ovf_set = {wrap1, wrap0 & ~(chain & run[1])};

  evt_pair_ovf u_ovf (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ovf_set),
    .clr_we_i(wr_en_i && (addr_i == A_OVF)), .clr_mask_i(wdata_i[1:0]),
    .ovf_o(ovf)
  );

  always_comb begin
    rdata_o = '0;
    case (reg_addr_e'(addr_i))
      A_CTRL:            rdata_o = {{(CNT_W-1){1'b0}}, glb};
      A_EN_SET, A_EN_CLR: rdata_o = {{(CNT_W-2){1'b0}}, en};
      A_OVF:             rdata_o = {{(CNT_W-2){1'b0}}, ovf};
      A_CNT0:            rdata_o = cnt0;
      A_CNT1:            rdata_o = cnt1;
      A_TYPE0:           rdata_o = {{(CNT_W-TYPE_W){1'b0}}, type0};
      A_TYPE1:           rdata_o = {{(CNT_W-TYPE_W){1'b0}}, type1};
      default: ;
    endcase
  end

  AST_CHAIN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && !run[0] && !ld0 && !ld1) |=> ($stable(cnt1) && $stable(cnt0))); // R4
  AST_CHAIN_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && run[1] && wrap0 && !ld1) |=> (cnt1 == $past(cnt1) + 1'b1)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain && run[1] && wrap0 && !ovf[0]) |=> !ovf[0]); // R5
  AST_OVF_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap0 && !(chain && run[1])) |=> ovf[0]); // R6
  AST_OVF_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap1 |=> ovf[1]); // R10
endmodule

// File: tb/evt_pair_ctr_tb.sv
`timescale 1ns/1ps
module evt_pair_ctr_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] evt_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [31:0] MEM = 32'h1 << 8'h13;
  localparam logic [31:0] CYC = 32'h1 << 8'h11;

  always #2.5 clk_i = ~clk_i;

  evt_pair_ctr u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i)
  );

  // reference state
  bit [31:0] m_c0, m_c1;
  bit [1:0]  m_ovf, m_en;
  bit        m_g;
  bit [4:0]  m_t0, m_t1;

  function automatic bit [31:0] m_read(bit [2:0] a);
    case (a)
      3'd0: return {31'd0, m_g};
      3'd1, 3'd2: return {30'd0, m_en};
      3'd3: return {30'd0, m_ovf};
      3'd4: return m_c0;
      3'd5: return m_c1;
      3'd6: return {27'd0, m_t0};
      default: return {27'd0, m_t1};
    endcase
  endfunction

  task automatic m_step(bit wr, bit [2:0] a, bit [31:0] d, bit [31:0] ev);
    bit e0 = m_g && m_en[0];
    bit e1 = m_g && m_en[1];
    bit ch = (m_t1 == 5'h1E);
    bit h0 = e0 && (m_t0 != 5'h1E) && ev[m_t0];
    bit w0 = wr && a == 3'd4;
    bit w1 = wr && a == 3'd5;
    bit [1:0] set = 2'b00;
    bit [31:0] n0 = m_c0, n1 = m_c1;
    if (ch && e1 && e0 && !w0 && !w1) begin
      longint unsigned wide = {m_c1, m_c0};
      if (h0) begin
        wide = wide + 1;
        if (wide == 0) set[1] = 1'b1;
      end
      n0 = wide[31:0];
      n1 = wide[63:32];
    end else begin
      bit carry = 1'b0;
      bit h1;
      if (w0) n0 = d;
      else if (h0) begin
        n0 = m_c0 + 1;
        carry = (m_c0 == 32'hFFFF_FFFF);
      end
      if (carry && !(ch && e1)) set[0] = 1'b1;
      h1 = e1 && (ch ? carry : ev[m_t1]);
      if (w1) n1 = d;
      else if (h1) begin
        n1 = m_c1 + 1;
        if (m_c1 == 32'hFFFF_FFFF) set[1] = 1'b1;
      end
    end
    m_c0 = n0;
    m_c1 = n1;
    m_ovf = (m_ovf & ~((wr && a == 3'd3) ? d[1:0] : 2'b00)) | set;
    if (wr) begin
      case (a)
        3'd0: m_g = d[0];
        3'd1: m_en = m_en | d[1:0];
        3'd2: m_en = m_en & ~d[1:0];
        3'd6: m_t0 = d[4:0];
        3'd7: m_t1 = d[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic check(string req, bit [31:0] act, bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive, compare with model, advance model
  task automatic cyc(bit wr, bit [2:0] a, bit [31:0] d, bit [31:0] ev, string req);
    wr_en_i = wr; addr_i = a; wdata_i = d; evt_i = ev;
    #1;
    check(req, rdata_o, m_read(a));
    @(posedge clk_i);
    m_step(wr, a, d, ev);
    @(negedge clk_i);
  endtask

  task automatic wr(bit [2:0] a, bit [31:0] d, string req);
    cyc(1'b1, a, d, '0, req);
  endtask

  task automatic run(int n, bit [31:0] ev, string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'(3 + (i % 3)), '0, ev, req);
  endtask

  task automatic expect_rd(bit [2:0] a, bit [31:0] exp, string req);
    wr_en_i = 1'b0; addr_i = a; evt_i = '0;
    #1;
    check(req, rdata_o, exp);
    @(posedge clk_i);
    m_step(1'b0, a, '0, '0);
    @(negedge clk_i);
  endtask

  task automatic sw_clear(string req);
    wr(3'd0, 32'd0, req);
    wr(3'd2, 32'd3, req);
    wr(3'd4, 32'd0, req);
    wr(3'd5, 32'd0, req);
    wr(3'd3, 32'd3, req);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R8 reset state
    expect_rd(3'd4, 32'd0, "R8");
    expect_rd(3'd5, 32'd0, "R8");
    expect_rd(3'd3, 32'd0, "R8");
    expect_rd(3'd1, 32'd0, "R8");
    expect_rd(3'd0, 32'd0, "R8");
    expect_rd(3'd7, 32'd0, "R8");

    // R4 chained odd, even disabled
    wr(3'd6, 32'h13, "R4"); wr(3'd7, 32'h1E, "R4");
    wr(3'd1, 32'd2, "R4"); wr(3'd0, 32'd1, "R4");
    run(20, MEM, "R4");
    expect_rd(3'd4, 32'd0, "R4");
    expect_rd(3'd5, 32'd0, "R4");

    // R6 only even enabled, wraps
    sw_clear("R6");
    wr(3'd4, 32'hFFFF_FFF0, "R6"); wr(3'd1, 32'd1, "R6"); wr(3'd0, 32'd1, "R6");
    run(20, MEM, "R6");
    expect_rd(3'd4, 32'd4, "R6");
    expect_rd(3'd5, 32'd0, "R6");
    expect_rd(3'd3, 32'd1, "R6");

    // R6 chain dropped by clearing odd enable mid-run
    sw_clear("R6");
    wr(3'd1, 32'd3, "R6"); wr(3'd4, 32'hFFFF_FFDC, "R6"); wr(3'd0, 32'd1, "R6");
    run(20, MEM, "R6");
    expect_rd(3'd4, 32'hFFFF_FFF0, "R6");
    wr(3'd2, 32'd2, "R6");
    run(20, MEM, "R6");
    expect_rd(3'd3, 32'd1, "R6");
    expect_rd(3'd5, 32'd0, "R6");

    // R5 chain enabled mid-run
    sw_clear("R5");
    wr(3'd1, 32'd1, "R5"); wr(3'd4, 32'hFFFF_FFDC, "R5"); wr(3'd0, 32'd1, "R5");
    run(20, MEM, "R5");
    wr(3'd1, 32'd3, "R5");
    run(20, MEM, "R5");
    expect_rd(3'd5, 32'd1, "R5");
    expect_rd(3'd3, 32'd0, "R5");
    expect_rd(3'd4, 32'd4, "R5");

    // R7 odd type cycles -> chain without reset
    sw_clear("R7");
    wr(3'd7, 32'h11, "R7"); wr(3'd1, 32'd3, "R7");
    wr(3'd4, 32'hFFFF_FFDC, "R7"); wr(3'd0, 32'd1, "R7");
    run(20, MEM, "R7");
    expect_rd(3'd5, 32'd0, "R7");
    wr(3'd7, 32'h1E, "R7");
    run(20, MEM, "R7");
    expect_rd(3'd5, 32'd1, "R7");
    expect_rd(3'd3, 32'd0, "R7");

    // R7 chain -> cycles
    sw_clear("R7");
    wr(3'd1, 32'd3, "R7"); wr(3'd4, 32'hFFFF_FFDC, "R7"); wr(3'd0, 32'd1, "R7");
    run(20, MEM, "R7");
    wr(3'd7, 32'h11, "R7");
    run(20, MEM, "R7");
    expect_rd(3'd3, 32'd1, "R7");
    expect_rd(3'd5, 32'd0, "R7");

    // R9 write-one-to-clear
    wr(3'd3, 32'd0, "R9");
    expect_rd(3'd3, 32'd1, "R9");
    wr(3'd3, 32'd1, "R9");
    expect_rd(3'd3, 32'd0, "R9");

    // R10 full chained wrap
    sw_clear("R10");
    wr(3'd7, 32'h1E, "R10");
    wr(3'd4, 32'hFFFF_FFFF, "R10"); wr(3'd5, 32'hFFFF_FFFF, "R10");
    wr(3'd1, 32'd3, "R10"); wr(3'd0, 32'd1, "R10");
    run(1, MEM, "R10");
    expect_rd(3'd4, 32'd0, "R10");
    expect_rd(3'd5, 32'd0, "R10");
    expect_rd(3'd3, 32'd2, "R10");

    // R11 write beats increment
    sw_clear("R11");
    wr(3'd1, 32'd1, "R11"); wr(3'd0, 32'd1, "R11");
    cyc(1'b1, 3'd4, 32'h55, MEM, "R11");
    expect_rd(3'd4, 32'h55, "R11");

    // R3 global enable off
    wr(3'd0, 32'd0, "R3");
    run(5, MEM, "R3");
    expect_rd(3'd4, 32'h55, "R3");

    // R1 type selects the input line
    wr(3'd6, 32'h11, "R1"); wr(3'd0, 32'd1, "R1");
    run(7, MEM, "R1");
    expect_rd(3'd4, 32'h55, "R1");
    run(7, CYC, "R1");
    expect_rd(3'd4, 32'h5C, "R1");
    wr(3'd6, 32'h1E, "R1");
    run(4, 32'hFFFF_FFFF, "R1");
    expect_rd(3'd4, 32'h5C, "R1");

    // R2 enable set/clear masks
    expect_rd(3'd1, 32'd1, "R2");
    wr(3'd1, 32'd2, "R2");
    expect_rd(3'd1, 32'd3, "R2");
    wr(3'd2, 32'd1, "R2");
    expect_rd(3'd2, 32'd2, "R2");

    // R9 flag raised in same cycle as its clear
    sw_clear("R9");
    wr(3'd6, 32'h13, "R9"); wr(3'd7, 32'h11, "R9");
    wr(3'd4, 32'hFFFF_FFFF, "R9"); wr(3'd1, 32'd1, "R9"); wr(3'd0, 32'd1, "R9");
    cyc(1'b1, 3'd3, 32'd1, MEM, "R9");
    expect_rd(3'd3, 32'd1, "R9");
    expect_rd(3'd4, 32'd0, "R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule